// File: doc/BRIEF.md
# Synchronous Burst SRAM Data Path

This block is the storage core and data path of a synchronous burst SRAM. It holds 32-bit words that are split into four byte lanes. It takes a word address each cycle from an external burst address generator, together with three chip enables and a set of write controls. All of these are captured on the rising clock edge. A write stores the whole word under a global-write override, or stores only the lanes picked by per-byte selects under a byte-write enable. A read returns the addressed word on a data output that reads as zero whenever it is not driven. An output-valid flag marks the cycles in which the output is driven.

A static mode input sets the read latency. With the mode low, the array read passes straight to the output, so data appears in the cycle after the address is captured. With the mode high, the data first passes through an output register and appears one cycle later. The pin is meant to be tied high when no other mode is wanted, which gives pipelined operation. Deselect uses single-cycle timing: in pipelined mode, the output turns off as soon as a deselect reaches the input registers, without waiting for the output register to drain. Output enable and sleep act on the output without a clock. Cycles captured while sleep is high do nothing, and the stored data is kept.

Top module: `sync_burst_sram`

## Requirements
- R1: While rst_ni is low, and after reset until a read arrives, rvalid_o is 0 and rdata_o is 0.
- R2: A cycle is selected only when ce0_ni is 0, ce1_i is 1 and ce2_ni is 0 on the capturing edge. Any other cycle is a deselect: it neither reads nor writes.
- R3: With pipe_mode_i at 0, a read captured at edge k drives the addressed word, with rvalid_o at 1, from edge k until edge k+1.
- R4: With pipe_mode_i at 1, a read captured at edge k drives its word from edge k+1 until edge k+2, provided the cycle captured at edge k+1 is selected.
- R5: With pipe_mode_i at 1, when a deselect is captured at edge k+1, the output is off from that edge on, even though a read captured at edge k is held in the output register.
- R6: With gw_ni at 1 and bwe_ni at 0, lane b (bits 8b+7:8b) is written exactly when bsel_ni[b] is 0, and all other lanes keep their data. With all four bsel_ni bits at 1, nothing is written and nothing is driven.
- R7: With gw_ni at 0, all four lanes are written whatever bwe_ni and bsel_ni are.
- R8: A read cycle is one with gw_ni and bwe_ni both at 1. A read captured in the cycle right after a write to the same address returns the newly written data.
- R9: While oe_ni is 1, rvalid_o is 0 at once, with no clock edge needed.
- R10: While sleep_i is 1, the output is off at once. A cycle captured with sleep_i at 1 neither reads nor writes, and the stored data is kept.
- R11: rdata_o is 0 in every cycle in which rvalid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address from the burst generator |
| wdata_i | input | 32 | Write data |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | 4 | Per-lane write selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| pipe_mode_i | input | 1 | 1 = pipelined, 0 = flow-through |
| rdata_o | output | 32 | Read data, zero when not driven |
| rvalid_o | output | 1 | Output driven flag |

## Verification
A wrong lane mask or a lost write stays hidden until the next read of that address. The bench therefore reads a small set of addresses often, so that stale data shows up on rdata_o within a few cycles. A wrong latency or a broken deselect path shows up in the very cycle it occurs, as rvalid_o high one cycle too early, too late or too long. Output enable and sleep are checked in the same sample in which they change.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef struct packed {
    logic             sel;
    logic             rd;
    logic [LANES-1:0] wmask;
  } req_ctl_t;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bsel_ni,
  input  logic              sleep_i,
  output req_ctl_t          ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q
);
  req_ctl_t ctl_d;
  logic     sel_d;

  assign sel_d = ~ce0_ni & ce1_i & ~ce2_ni & ~sleep_i;

  always_comb begin
    ctl_d.sel   = sel_d;
    ctl_d.rd    = sel_d & gw_ni & bwe_ni;
    ctl_d.wmask = '0;
    if (sel_d) begin
      if (!gw_ni)       ctl_d.wmask = '1;
      else if (!bwe_ni) ctl_d.wmask = ~bsel_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wmask_i[g]) mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] ft_data_i,
  input  logic              ft_rd_i,
  input  logic              cur_sel_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [WORD_W-1:0] pdata_q;
  logic              prd_q;
  logic              path_drive;
  logic              drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdata_q <= '0;
      prd_q   <= 1'b0;
    end else begin
      pdata_q <= ft_data_i;
      prd_q   <= ft_rd_i;
    end
  end

  // single-cycle deselect: a deselect in the input stage cuts the pipe path
  assign path_drive = pipe_mode_i ? (prd_q & cur_sel_i) : ft_rd_i;
  assign drive      = path_drive & ~oe_ni & ~sleep_i;
  assign rvalid_o   = drive;
  assign rdata_o    = drive ? (pipe_mode_i ? pdata_q : ft_data_i) : '0;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bsel_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic              pipe_mode_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  req_ctl_t          ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] arr_rdata;

  sram_in_stage #(.ADDR_W(ADDR_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ce0_ni  (ce0_ni),
    .ce1_i   (ce1_i),
    .ce2_ni  (ce2_ni),
    .gw_ni   (gw_ni),
    .bwe_ni  (bwe_ni),
    .bsel_ni (bsel_ni),
    .sleep_i (sleep_i),
    .ctl_q   (ctl_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q)
  );

  sram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i   (clk_i),
    .wmask_i (ctl_q.wmask),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .rdata_o (arr_rdata)
  );

  sram_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .oe_ni       (oe_ni),
    .sleep_i     (sleep_i),
    .ft_data_i   (arr_rdata),
    .ft_rd_i     (ctl_q.rd),
    .cur_sel_i   (ctl_q.sel),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );
endmodule

// File: rtl/sram_checker.sv
module sram_checker
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              ce0_ni,
  input logic              ce1_i,
  input logic              ce2_ni,
  input logic              gw_ni,
  input logic              bwe_ni,
  input logic [LANES-1:0]  bsel_ni,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic              pipe_mode_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o
);
  logic sel_in;
  logic rd_in;
  assign sel_in = ~ce0_ni & ce1_i & ~ce2_ni & ~sleep_i;
  assign rd_in  = sel_in & gw_ni & bwe_ni;

  a_r11_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));

  a_r9_oe_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rvalid_o);

  a_r10_sleep_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rvalid_o);

  a_r3_flow_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !pipe_mode_i && !oe_ni && !sleep_i && $past(rd_in)) |-> rvalid_o);

  a_r4_pipe_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && pipe_mode_i && !oe_ni && !sleep_i && $past(rd_in, 2) && $past(sel_in))
    |-> rvalid_o);

  a_r5_scd_cutoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && pipe_mode_i && !$past(sel_in)) |-> !rvalid_o);
endmodule

bind sync_burst_sram sram_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              ce0_ni = 1'b1, ce1_i = 1'b0, ce2_ni = 1'b1;
  logic              gw_ni = 1'b1, bwe_ni = 1'b1;
  logic [3:0]        bsel_ni = 4'hf;
  logic              oe_ni = 1'b0, sleep_i = 1'b0, pipe_mode_i = 1'b0;
  logic [31:0]       rdata_o;
  logic              rvalid_o;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  logic [31:0] mem_m [16];
  bit          prev_rd = 0;
  logic [31:0] prev_data = '0;

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .ce0_ni(ce0_ni), .ce1_i(ce1_i), .ce2_ni(ce2_ni), .gw_ni(gw_ni),
    .bwe_ni(bwe_ni), .bsel_ni(bsel_ni), .oe_ni(oe_ni), .sleep_i(sleep_i),
    .pipe_mode_i(pipe_mode_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // op: 0 read, 1 global write, 2 byte write, 3 deselect
  task automatic step(input logic [3:0] a, input logic [31:0] w, input int op,
                      input logic [3:0] bs, input bit oe, input bit slp, input bit mode,
                      input string tag);
    bit sel_now, rd_now, ev;
    logic [31:0] ftd, ed;
    logic [3:0] wm;
    string t;
    @(negedge clk);
    sel_now = !ce0_ni && ce1_i && !ce2_ni && !sleep_i;
    rd_now  = sel_now && gw_ni && bwe_ni;
    ftd     = mem_m[addr_i[3:0]];
    if (pipe_mode_i) begin
      ev = !oe_ni && !sleep_i && sel_now && prev_rd;
      ed = ev ? prev_data : 32'h0;
    end else begin
      ev = !oe_ni && !sleep_i && rd_now;
      ed = ev ? ftd : 32'h0;
    end
    if (tag != "") t = tag;
    else if (sleep_i) t = "R10";
    else if (oe_ni) t = "R9";
    else if (pipe_mode_i) t = sel_now ? "R4" : "R5";
    else t = "R3";
    check({t, " valid"}, {31'd0, rvalid_o}, {31'd0, ev});
    check({t, " data/R11"}, rdata_o, ed);
    prev_rd   = rd_now;
    prev_data = ftd;
    wm = !sel_now ? 4'h0 : (!gw_ni ? 4'hf : (!bwe_ni ? ~bsel_ni : 4'h0));
    for (int b = 0; b < 4; b++)
      if (wm[b]) mem_m[addr_i[3:0]][b*8 +: 8] = wdata_i[b*8 +: 8];
    // drive next
    addr_i  = {{(ADDR_W-4){1'b0}}, a};
    wdata_i = w;
    ce0_ni = 1'b0; ce1_i = 1'b1; ce2_ni = 1'b0;
    gw_ni = 1'b1; bwe_ni = 1'b1; bsel_ni = bs;
    case (op)
      1: gw_ni = 1'b0;
      2: bwe_ni = 1'b0;
      3: case (w[1:0])
           2'd0: ce0_ni = 1'b1;
           2'd1: ce1_i = 1'b0;
           default: ce2_ni = 1'b1;
         endcase
      default: ;
    endcase
    oe_ni = oe; sleep_i = slp; pipe_mode_i = mode;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit mode;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, rvalid_o}, 32'd0);
    check("R1 data in reset", rdata_o, 32'd0);
    rst_ni = 1'b1;
    // R7: fill with global writes, byte controls set to noise
    for (int i = 0; i < 16; i++)
      step(i[3:0], 32'hA5000000 + i * 32'h01010101, 1, i[3:0], 0, 0, 0, "R1");
    step(4'd3, 0, 0, 4'hf, 0, 0, 0, "R7");
    step(4'd4, 0, 0, 4'hf, 0, 0, 0, "R7");
    // R6: lanes 0 and 2 written (bsel_ni = 1010), then R8 immediate read
    step(4'd5, 32'h11223344, 2, 4'b1010, 0, 0, 0, "R3");
    step(4'd5, 0, 0, 4'hf, 0, 0, 0, "R6");
    step(4'd6, 32'hdeadbeef, 2, 4'hf, 0, 0, 0, "R8");
    step(4'd6, 0, 0, 4'hf, 0, 0, 0, "R6");
    // R2: deselected write must not land
    step(4'd7, 32'h00000001, 3, 4'h0, 0, 0, 0, "R6");
    step(4'd7, 0, 0, 4'hf, 0, 0, 0, "R2");
    step(4'd7, 0, 3, 4'hf, 0, 0, 0, "R2");
    // pipelined: reads, then deselect cuts off (R5), then read followed by write
    step(4'd1, 0, 0, 4'hf, 0, 0, 1, "R3");
    step(4'd2, 0, 0, 4'hf, 0, 0, 1, "R4");
    step(4'd0, 32'd2, 3, 4'hf, 0, 0, 1, "R4");
    step(4'd3, 0, 0, 4'hf, 0, 0, 1, "R5");
    step(4'd4, 32'hcafef00d, 1, 4'hf, 0, 0, 1, "R4");
    step(4'd4, 0, 0, 4'hf, 0, 0, 1, "R4");
    step(4'd4, 0, 0, 4'hf, 0, 0, 1, "R8");
    // R10: write during sleep ignored, data kept
    step(4'd8, 32'h0badf00d, 1, 4'hf, 0, 1, 1, "R4");
    step(4'd8, 0, 0, 4'hf, 0, 0, 1, "R10");
    step(4'd8, 0, 0, 4'hf, 1, 0, 1, "R10");
    step(4'd9, 0, 0, 4'hf, 0, 0, 1, "R9");
    step(4'd9, 0, 3, 4'hf, 0, 0, 0, "R10");
    // random phase
    mode = 0;
    for (int i = 0; i < 4000; i++) begin
      int r, op;
      if (i % 64 == 0) mode = ~mode;
      r  = $urandom_range(0, 99);
      op = (r < 45) ? 0 : (r < 60) ? 1 : (r < 85) ? 2 : 3;
      step(4'($urandom_range(0, 15)), $urandom, op, 4'($urandom_range(0, 15)),
           ($urandom_range(0, 99) < 12), ($urandom_range(0, 99) < 5), mode, "");
    end
    repeat (3) step(4'd0, 0, 3, 4'hf, 0, 0, mode, "");
    done = 1;
    summary();
    $finish;
  end
endmodule